// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block drives a four-digit display in which every digit has its own BCD-to-seven-segment decoder. The host supplies the four decimal digits packed into one 16-bit word. The block asserts one digit-select line at a time and places the matching 4-bit BCD code on a nibble bus shared by all digits. Segment decoding is done inside the display.

A prescaler sets how long each digit stays lit. A sequencer walks the select lines in a fixed order and repeats forever. The walk is fast enough that the eye sees all four digits as steady. The select lines are not wired in digit order, so the block holds a fixed table that maps each digit slot to its physical line. Each digit's input value is captured at the start of its own slot. The select line and the nibble change on the same clock edge, so a digit never shows a neighbour's code.

Top module: `bcd_digit_scanner`

## Requirements
- R1: At most one bit of `digitEn` is high in any cycle. From the first clock edge after reset is released, exactly one bit is high.
- R2: The physical select lines sit at fixed `digitEn` bits. The ones line is bit 3, the tens line is bit 0, the hundreds line is bit 1 and the thousands line is bit 2.
- R3: While a line is selected, `nibble` carries that digit's BCD code. The codes come from `bcdIn[3:0]` for ones, `[7:4]` for tens, `[11:8]` for hundreds and `[15:12]` for thousands. The nibble changes on the same clock edge as the select.
- R4: The scan runs ones, then tens, then hundreds, then thousands, then back to ones, and repeats without end.
- R5: The reset is synchronous and active high. On a clock edge with `rst` high, `digitEn` goes to 0000 and `nibble` goes to 0000. The first edge after `rst` falls selects the ones digit, so `digitEn` becomes 1000.
- R6: Each digit stays selected for exactly `SLOT_CYCLES` clock cycles before the next digit takes over.
- R7: A digit's value is captured from `bcdIn` on the edge that starts its slot. A change to `bcdIn` during a slot does not alter the nibble shown in that slot. The change appears the next time that digit's slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcdIn | input | 16 | Four packed BCD digits; ones in the lowest nibble |
| digitEn | output | 4 | One-hot, active-high select lines, mapped as in R2 |
| nibble | output | 4 | BCD code of the selected digit |

## Verification
Some internal faults show at the ports within one digit slot. A corrupted slot index makes the next select line appear out of order, or shows a code taken from the wrong field of `bcdIn`. A prescaler that miscounts shortens or stretches a slot, which shows up by the next line change. A capture register that loads outside a slot boundary lets a change made mid-slot reach the display early, which is visible in the same slot. A lost start flag after reset leaves every select line low from the first cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int DIGITS = 4;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = $clog2(DIGITS);

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic             load;     // start a new digit slot on this edge
    logic [IDX_W-1:0] nextIdx;  // logical slot: 0 ones .. 3 thousands
  } scanStrobe_t;

  // Fixed wiring of logical slots to physical select bits
  function automatic logic [DIGITS-1:0] lineForSlot(input logic [IDX_W-1:0] idx);
    logic [DIGITS-1:0] en;
    case (idx)
      2'd0:    en = 4'b1000;  // ones
      2'd1:    en = 4'b0001;  // tens
      2'd2:    en = 4'b0010;  // hundreds
      default: en = 4'b0100;  // thousands
    endcase
    return en;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rst,
  output scanStrobe_t strobe
);

  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);

  logic             running;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] curIdx;
  logic             slotEnd;

  assign slotEnd = running && (tickCnt == CNT_LAST);

  always_comb begin
    strobe.load    = !running || slotEnd;
    strobe.nextIdx = running ? IDX_W'(curIdx + 1'b1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      tickCnt <= '0;
      curIdx  <= '0;
    end else begin
      running <= 1'b1;
      if (strobe.load) begin
        tickCnt <= '0;
        curIdx  <= strobe.nextIdx;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  scanStrobe_t             strobe,
  input  logic [DIGITS*NIB_W-1:0] bcdIn,
  output logic [DIGITS-1:0]       digitEn,
  output logic [NIB_W-1:0]        nibble
);

  logic [NIB_W-1:0] digitField [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_split
    assign digitField[g] = bcdIn[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digitEn <= '0;
      nibble  <= '0;
    end else if (strobe.load) begin
      digitEn <= lineForSlot(strobe.nextIdx);
      nibble  <= digitField[strobe.nextIdx];
    end
  end

endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bcdIn,
  output logic [3:0]  digitEn,
  output logic [3:0]  nibble
);

  scanStrobe_t strobe;

  scan_ctrl #(.SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  scan_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .bcdIn   (bcdIn),
    .digitEn (digitEn),
    .nibble  (nibble)
  );

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int SLOT_CYCLES = 100000
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bcdIn,
  input logic [3:0]  digitEn,
  input logic [3:0]  nibble
);

  localparam int HW = $clog2(SLOT_CYCLES + 1) + 1;

  logic [3:0]    prevEn;
  logic [15:0]   prevIn;
  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevEn  <= '0;
      prevIn  <= '0;
      holdCnt <= '0;
    end else begin
      prevEn <= digitEn;
      prevIn <= bcdIn;
      if (digitEn != prevEn) holdCnt <= '0;
      else if (holdCnt != '1) holdCnt <= holdCnt + 1'b1;
    end
  end

  function automatic logic [3:0] successor(input logic [3:0] en);
    case (en)
      4'b1000: return 4'b0001;
      4'b0001: return 4'b0010;
      4'b0010: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [3:0] fieldFor(input logic [3:0] en, input logic [15:0] w);
    case (en)
      4'b1000: return w[3:0];
      4'b0001: return w[7:4];
      4'b0010: return w[11:8];
      default: return w[15:12];
    endcase
  endfunction

  // R1
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(digitEn));

  // R3, R7
  p_nibble_r3: assert property (@(posedge clk) disable iff (rst)
    (digitEn != prevEn && digitEn != 4'b0000) |-> nibble == fieldFor(digitEn, prevIn));

  // R7: nibble frozen inside a slot
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (digitEn == prevEn && digitEn != 4'b0000) |-> $stable(nibble));

  // R2, R4
  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    (prevEn != 4'b0000 && digitEn != prevEn) |-> digitEn == successor(prevEn));

  // R5
  p_reset_r5: assert property (@(posedge clk) rst |=> (digitEn == 4'b0000 && nibble == 4'b0000));
  p_start_r5: assert property (@(posedge clk) disable iff (rst) $fell(rst) |=> digitEn == 4'b1000);

  // R6
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (prevEn != 4'b0000 && digitEn != prevEn) |-> holdCnt == HW'(SLOT_CYCLES - 1));

endmodule

bind bcd_digit_scanner scan_checker #(.SLOT_CYCLES(SLOT_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bcdIn   (bcdIn),
  .digitEn (digitEn),
  .nibble  (nibble)
);

// File: tb/bcd_digit_scanner_test.sv
module bcd_digit_scanner_test;

  localparam int SLOT = 4;
  localparam int NVEC = 4;
  localparam logic [15:0] VEC [NVEC] = '{16'h1234, 16'h9087, 16'h0000, 16'h5959};
  localparam logic [3:0]  EXP_EN [4] = '{4'b1000, 4'b0001, 4'b0010, 4'b0100};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bcdIn = '0;
  logic [3:0]  digitEn;
  logic [3:0]  nibble;

  int checks = 0;
  int fails  = 0;
  int multiHot = 0;

  always #5 clk = ~clk;

  bcd_digit_scanner #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst(rst), .bcdIn(bcdIn), .digitEn(digitEn), .nibble(nibble)
  );

  always @(negedge clk) if (!rst && $countones(digitEn) > 1) multiHot++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reset, check reset state, release; returns at negedge inside ones slot
  task automatic startScan(input logic [15:0] val);
    @(negedge clk);
    rst = 1'b1;
    bcdIn = val;
    @(negedge clk);
    check("R5 reset selects", {12'h0, digitEn}, 16'h0);
    check("R5 reset nibble", {12'h0, nibble}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Vector table: five slots each, covering wrap back to ones (R4)
    for (int v = 0; v < NVEC; v++) begin
      startScan(VEC[v]);
      for (int s = 0; s < 5; s++) begin
        check("R2 R4 select line", {12'h0, digitEn}, {12'h0, EXP_EN[s % 4]});
        check("R3 nibble", {12'h0, nibble}, {12'h0, VEC[v][(s % 4)*4 +: 4]});
        repeat (SLOT) @(negedge clk);
      end
    end

    // R6: ones slot lasts exactly SLOT cycles
    startScan(16'h4321);
    begin
      int n = 0;
      while (digitEn == 4'b1000 && n < 20) begin
        n++;
        @(negedge clk);
      end
      check("R6 slot length", 16'(n), 16'(SLOT));
      check("R6 next is tens", {12'h0, digitEn}, 16'h0001);
    end

    // R7: mid-slot change
    startScan(16'h4321);
    bcdIn = 16'h9876;
    @(negedge clk);
    check("R7 ones held mid-slot", {12'h0, nibble}, 16'h1);
    repeat (SLOT - 1) @(negedge clk);
    check("R7 tens takes new value", {12'h0, nibble}, 16'h7);
    repeat (SLOT) @(negedge clk);
    check("R7 hundreds new", {12'h0, nibble}, 16'h8);
    repeat (SLOT) @(negedge clk);
    check("R7 thousands new", {12'h0, nibble}, 16'h9);
    repeat (SLOT) @(negedge clk);
    check("R7 ones new on revisit", {12'h0, nibble}, 16'h6);

    // R5: reset mid-scan restarts at ones
    startScan(16'h2468);
    repeat (SLOT + 2) @(negedge clk);
    check("R5 mid-scan in tens", {12'h0, digitEn}, 16'h0001);
    rst = 1'b1;
    @(negedge clk);
    check("R5 mid-scan reset clears", {8'h0, digitEn, nibble}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 restart at ones", {8'h0, digitEn, nibble}, {8'h0, 4'b1000, 4'h8});

    check("R1 never multi-hot", 16'(multiHot), 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule